// File: doc/BRIEF.md
# Stream Staging FIFO

This block buffers the data of one transfer stream between the side that reads the source and the side that writes the destination. It holds 16 bytes, organised as a byte ring. The source side pushes items of 1, 2 or 4 bytes. The destination side pops items of its own width, and bytes are packed and unpacked little-endian. In buffered mode the destination is asked to drain once a programmable fill level is reached. In direct mode each item passes straight through, one at a time, and the next source item is fetched as soon as the ring is empty.

When the stream is enabled, the block checks in the same cycle that the fill threshold holds a whole number of destination bursts, and that one burst fits in the ring. A failing check raises a sticky error and the stream stays off. When the stream is disabled, contents bound for memory are drained to the end and completion is signalled afterwards. Contents bound for a peripheral are discarded.

Top module: `stream_stage_fifo`

## Requirements
- R1: After reset the stream is inactive, the level is 0, and all flags, requests, `pop_valid` and `xfer_done` are low.
- R2: The check runs on a rising `en_req` while inactive, in buffered mode (`buffered`=1). Burst bytes = beats (`burst_sel` 0/1/2/3 gives 1/4/8/16) times destination item bytes (`dst_sz` 0/1/2 gives 1/2/4, 3 gives 4). Threshold bytes = 4 times (`thr_sel`+1). If the burst bytes exceed 16, or the threshold is not a multiple of the burst bytes, `fifo_err` is set and `active` stays 0. Otherwise `active` goes to 1 after that clock edge.
- R3: In direct mode (`buffered`=0) the threshold and burst settings are not checked at enable. The destination item width equals the source width. `fetch_req` is high while active and empty, which preloads one item. `drain_req` is high once one item is held.
- R4: In buffered mode while active, `drain_req` is high exactly when the level is at least the threshold bytes.
- R5: An accepted push adds `src_sz` bytes (same encoding as `dst_sz`) from `push_data` bits [7:0] upward. A pop returns the oldest bytes in `pop_data`, with the oldest byte in [7:0].
- R6: A push while active, with fewer free bytes than the source item, is dropped. It sets the sticky `overrun` flag, which stays set until `clr_flags`.
- R7: A pop while active, with fewer stored bytes than the destination item, returns nothing. It sets the sticky `underrun` flag, which `clr_flags` clears.
- R8: Disabling a stream with `dir` 0 (peripheral to memory) or 2 (memory to memory) keeps `drain_req` high while bytes remain. A final short item is popped zero-padded. `xfer_done` pulses for one cycle, one clock after the level reaches 0.
- R9: Disabling a stream with `dir` 1 (memory to peripheral) empties the ring at that clock edge, and no `xfer_done` follows.
- R10: A push and a pop in the same cycle both take effect: the new level = old level + pushed bytes - popped bytes.
- R11: `pop_data` and `pop_valid` are registered. `pop_valid` is high for exactly the cycle after an accepted pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_req | input | 1 | Stream enable level |
| buffered | input | 1 | 1 = threshold mode, 0 = direct mode |
| thr_sel | input | 2 | Fill threshold, quarter steps |
| burst_sel | input | 2 | Destination burst beats |
| src_sz | input | 2 | Source item size |
| dst_sz | input | 2 | Destination item size |
| dir | input | 2 | Transfer direction |
| push | input | 1 | Source item present |
| push_data | input | 32 | Source item, little-endian |
| pop | input | 1 | Destination takes an item |
| clr_flags | input | 1 | Clears the sticky flags |
| active | output | 1 | Stream running |
| fetch_req | output | 1 | Room for a source item |
| drain_req | output | 1 | Destination should drain |
| pop_valid | output | 1 | Popped item valid |
| pop_data | output | 32 | Popped item |
| level | output | 5 | Stored bytes |
| fifo_err | output | 1 | Sticky configuration error |
| overrun | output | 1 | Sticky push-while-full |
| underrun | output | 1 | Sticky pop-while-empty |
| xfer_done | output | 1 | Flush-complete pulse |

## Verification
Push and pop can be accepted in the same clock, and when they are, the byte ring is written and read at once. The bench fills the ring to 12 bytes with 32-bit pushes and 16-bit pops. It then raises `push` and `pop` together for one cycle. The result is judged in three ways: the level must read 14, the returned half-word must be the oldest stored one, and a later flush must return the pushed word's halves last, in order.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  // Direction codes.
  localparam logic [1:0] DIR_P2M = 2'd0;
  localparam logic [1:0] DIR_M2P = 2'd1;
  localparam logic [1:0] DIR_M2M = 2'd2;

  // Item size code to byte count; code 3 treated as a word.
  function automatic logic [2:0] item_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // Burst code to beat count.
  function automatic logic [4:0] burst_beats(input logic [1:0] b);
    case (b)
      2'd0:    return 5'd1;
      2'd1:    return 5'd4;
      2'd2:    return 5'd8;
      default: return 5'd16;
    endcase
  endfunction
endpackage

// File: rtl/sfifo_cfg_check.sv
// Enable-time validation of threshold against destination burst size.
module sfifo_cfg_check #(
  parameter int FIFO_BYTES = 16
) (
  input  logic       buffered,
  input  logic [1:0] thr_sel,
  input  logic [1:0] burst_sel,
  input  logic [1:0] dst_sz,
  output logic       cfg_ok
);
  import sfifo_pkg::*;
  localparam int BW = $clog2(FIFO_BYTES * 4) + 1;
  localparam int QB = FIFO_BYTES / 4;

  logic [BW-1:0] burst_b;
  logic [BW-1:0] thr_b;

  // Burst bytes are a power of two, so divisibility reduces to a mask.
  always_comb begin
    burst_b = BW'(burst_beats(burst_sel)) * BW'(item_bytes(dst_sz));
    thr_b   = BW'(QB) * (BW'(thr_sel) + BW'(1));
    cfg_ok  = !buffered ||
              ((burst_b <= BW'(FIFO_BYTES)) && ((thr_b & (burst_b - BW'(1))) == '0));
  end
endmodule

// File: rtl/sfifo_ring.sv
// Byte-granular ring; FIFO_BYTES must be a power of two.
module sfifo_ring #(
  parameter int FIFO_BYTES = 16,
  parameter int WB         = 4,
  localparam int PW = $clog2(FIFO_BYTES),
  localparam int LW = $clog2(FIFO_BYTES + 1),
  localparam int CW = $clog2(WB + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            push_en,
  input  logic            push,
  input  logic [8*WB-1:0] push_data,
  input  logic [CW-1:0]   push_n,
  input  logic            pop_en,
  input  logic            pop,
  input  logic [CW-1:0]   pop_n,
  input  logic            partial,
  output logic [LW-1:0]   level,
  output logic            pop_valid,
  output logic [8*WB-1:0] pop_data,
  output logic            ovf_evt,
  output logic            unf_evt
);
  logic [7:0]      mem [FIFO_BYTES];
  logic [PW-1:0]   wr_ptr, rd_ptr;
  logic            push_ok, pop_ok, have_full;
  logic [CW-1:0]   take;
  logic [8*WB-1:0] rd_bytes;

  always_comb begin
    push_ok   = push_en && push && ((LW'(FIFO_BYTES) - level) >= LW'(push_n));
    ovf_evt   = push_en && push && !push_ok;
    have_full = level >= LW'(pop_n);
    pop_ok    = pop_en && pop && (have_full || (partial && level != '0));
    unf_evt   = pop_en && pop && !pop_ok;
    take      = have_full ? pop_n : CW'(level);
    for (int i = 0; i < WB; i++) begin
      rd_bytes[8*i +: 8] = (CW'(i) < take) ? mem[rd_ptr + PW'(i)] : 8'h00;
    end
  end

  // Storage has no reset.
  always_ff @(posedge clk) begin
    for (int i = 0; i < WB; i++) begin
      if (push_ok && !clear && (CW'(i) < push_n)) begin
        mem[wr_ptr + PW'(i)] <= push_data[8*i +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      level     <= '0;
      pop_valid <= 1'b0;
      pop_data  <= '0;
    end else if (clear) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      level     <= '0;
      pop_valid <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + PW'(push_n);
      if (pop_ok)  rd_ptr <= rd_ptr + PW'(take);
      level     <= level + (push_ok ? LW'(push_n) : LW'(0)) - (pop_ok ? LW'(take) : LW'(0));
      pop_valid <= pop_ok;
      if (pop_ok) pop_data <= rd_bytes;
    end
  end
endmodule

// File: rtl/sfifo_ctrl.sv
// Enable/disable sequencing, flush tracking and sticky flags.
module sfifo_ctrl #(
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_req,
  input  logic          cfg_ok,
  input  logic [1:0]    dir,
  input  logic [LW-1:0] level,
  input  logic          ovf_evt,
  input  logic          unf_evt,
  input  logic          clr_flags,
  output logic          active,
  output logic          flushing,
  output logic          ring_clear,
  output logic          xfer_done,
  output logic          fifo_err,
  output logic          overrun,
  output logic          underrun
);
  import sfifo_pkg::*;
  logic en_q, start, stop;

  always_comb begin
    start      = en_req && !en_q && !active && !flushing;
    stop       = active && !en_req;
    ring_clear = (start && cfg_ok) || (stop && dir == DIR_M2P);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      active    <= 1'b0;
      flushing  <= 1'b0;
      xfer_done <= 1'b0;
      fifo_err  <= 1'b0;
      overrun   <= 1'b0;
      underrun  <= 1'b0;
    end else begin
      en_q      <= en_req;
      xfer_done <= 1'b0;
      if (clr_flags) begin
        fifo_err <= 1'b0;
        overrun  <= 1'b0;
        underrun <= 1'b0;
      end
      if (start) begin
        active <= cfg_ok;
        if (!cfg_ok) fifo_err <= 1'b1;
      end
      if (stop) begin
        active   <= 1'b0;
        flushing <= (dir != DIR_M2P);
      end
      if (flushing && level == '0) begin
        flushing  <= 1'b0;
        xfer_done <= 1'b1;
      end
      if (ovf_evt) overrun  <= 1'b1;
      if (unf_evt) underrun <= 1'b1;
    end
  end
endmodule

// File: rtl/stream_stage_fifo.sv
module stream_stage_fifo #(
  parameter int FIFO_BYTES = 16,
  parameter int WORD_BYTES = 4,
  localparam int LW = $clog2(FIFO_BYTES + 1),
  localparam int DW = 8 * WORD_BYTES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_req,
  input  logic          buffered,
  input  logic [1:0]    thr_sel,
  input  logic [1:0]    burst_sel,
  input  logic [1:0]    src_sz,
  input  logic [1:0]    dst_sz,
  input  logic [1:0]    dir,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic          clr_flags,
  output logic          active,
  output logic          fetch_req,
  output logic          drain_req,
  output logic          pop_valid,
  output logic [DW-1:0] pop_data,
  output logic [LW-1:0] level,
  output logic          fifo_err,
  output logic          overrun,
  output logic          underrun,
  output logic          xfer_done
);
  import sfifo_pkg::*;
  localparam int CW = $clog2(WORD_BYTES + 1);
  localparam int QB = FIFO_BYTES / 4;

  logic          cfg_ok, flushing, ring_clear, ovf_evt, unf_evt;
  logic [CW-1:0] push_n, pop_n;
  logic [LW-1:0] thr_b;

  always_comb begin
    push_n = CW'(item_bytes(src_sz));
    pop_n  = CW'(item_bytes(buffered ? dst_sz : src_sz));
    thr_b  = LW'(QB) * (LW'(thr_sel) + LW'(1));
    if (active) begin
      drain_req = buffered ? (level >= thr_b) : (level >= LW'(pop_n));
      fetch_req = buffered ? ((LW'(FIFO_BYTES) - level) >= LW'(push_n)) : (level == '0);
    end else begin
      drain_req = flushing && (level != '0);
      fetch_req = 1'b0;
    end
  end

  sfifo_cfg_check #(.FIFO_BYTES(FIFO_BYTES)) u_check (
    .buffered (buffered),
    .thr_sel  (thr_sel),
    .burst_sel(burst_sel),
    .dst_sz   (dst_sz),
    .cfg_ok   (cfg_ok)
  );

  sfifo_ring #(.FIFO_BYTES(FIFO_BYTES), .WB(WORD_BYTES)) u_ring (
    .clk      (clk),
    .rst      (rst),
    .clear    (ring_clear),
    .push_en  (active),
    .push     (push),
    .push_data(push_data),
    .push_n   (push_n),
    .pop_en   (active || flushing),
    .pop      (pop),
    .pop_n    (pop_n),
    .partial  (flushing),
    .level    (level),
    .pop_valid(pop_valid),
    .pop_data (pop_data),
    .ovf_evt  (ovf_evt),
    .unf_evt  (unf_evt)
  );

  sfifo_ctrl #(.LW(LW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .en_req    (en_req),
    .cfg_ok    (cfg_ok),
    .dir       (dir),
    .level     (level),
    .ovf_evt   (ovf_evt),
    .unf_evt   (unf_evt),
    .clr_flags (clr_flags),
    .active    (active),
    .flushing  (flushing),
    .ring_clear(ring_clear),
    .xfer_done (xfer_done),
    .fifo_err  (fifo_err),
    .overrun   (overrun),
    .underrun  (underrun)
  );
endmodule

// File: rtl/stream_stage_fifo_chk.sv
module stream_stage_fifo_chk #(
  parameter int FIFO_BYTES = 16,
  localparam int LW = $clog2(FIFO_BYTES + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          push,
  input logic          pop,
  input logic [1:0]    src_sz,
  input logic [1:0]    dir,
  input logic [LW-1:0] level,
  input logic          active,
  input logic          fifo_err,
  input logic          overrun,
  input logic          underrun,
  input logic          xfer_done,
  input logic          pop_valid
);
  import sfifo_pkg::*;

  assert_level_cap_R10: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(FIFO_BYTES));

  assert_err_blocks_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(fifo_err) |-> !active);

  assert_overrun_R6: assert property (@(posedge clk) disable iff (rst)
    (push && active && (level > (LW'(FIFO_BYTES) - LW'(item_bytes(src_sz))))) |=> overrun);

  assert_underrun_R7: assert property (@(posedge clk) disable iff (rst)
    (pop && active && level == '0) |=> underrun);

  assert_done_empty_R8: assert property (@(posedge clk) disable iff (rst)
    xfer_done |-> level == '0);

  assert_discard_R9: assert property (@(posedge clk) disable iff (rst)
    ($fell(active) && $past(dir) == DIR_M2P) |-> level == '0);

  assert_pop_valid_R11: assert property (@(posedge clk) disable iff (rst)
    pop_valid |-> $past(pop));
endmodule

bind stream_stage_fifo stream_stage_fifo_chk #(.FIFO_BYTES(FIFO_BYTES)) u_chk (.*);

// File: tb/stream_stage_fifo_bench.sv
module stream_stage_fifo_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst, en_req, buffered, push, pop, clr_flags;
  logic [1:0]  thr_sel, burst_sel, src_sz, dst_sz, dir;
  logic [31:0] push_data, pop_data;
  logic        active, fetch_req, drain_req, pop_valid;
  logic [4:0]  level;
  logic        fifo_err, overrun, underrun, xfer_done;
  int errs = 0;
  int checks = 0;
  logic finished = 1'b0;

  stream_stage_fifo u_stream_stage_fifo (.*);

  // {buffered, thr_sel, burst_sel, dst_sz, expect_err}
  localparam logic [7:0] VEC [8] = '{
    8'b1_00_01_00_0, 8'b1_00_01_01_1, 8'b1_11_11_00_0, 8'b1_11_10_01_0,
    8'b1_11_11_10_1, 8'b1_10_10_00_1, 8'b1_10_00_10_0, 8'b0_10_11_10_0
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_push(input logic [31:0] d);
    push = 1'b1; push_data = d; step(); push = 1'b0;
  endtask

  task automatic do_pop();
    pop = 1'b1; step(); pop = 1'b0;
  endtask

  task automatic cfg(input logic b, input logic [1:0] t, input logic [1:0] bu,
                     input logic [1:0] s, input logic [1:0] d, input logic [1:0] dr);
    buffered = b; thr_sel = t; burst_sel = bu; src_sz = s; dst_sz = d; dir = dr;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; en_req = 0; push = 0; pop = 0; clr_flags = 0; push_data = '0;
    cfg(1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0);
    @(negedge clk);
    repeat (3) step();
    rst = 1'b0;
    step();
    // R1 reset state
    chk("R1 active", active, 0);
    chk("R1 level", level, 0);
    chk("R1 flags", {fifo_err, overrun, underrun, xfer_done}, 0);
    chk("R1 reqs", {fetch_req, drain_req, pop_valid}, 0);

    // R2 / R3 enable check vectors
    for (int i = 0; i < 8; i++) begin
      cfg(VEC[i][7], VEC[i][6:5], VEC[i][4:3], 2'd0, VEC[i][2:1], 2'd0);
      en_req = 1'b1; step();
      chk(VEC[i][7] ? "R2 active" : "R3 active", active, !VEC[i][0]);
      chk(VEC[i][7] ? "R2 err" : "R3 err", fifo_err, VEC[i][0]);
      en_req = 1'b0; clr_flags = 1'b1; step();
      clr_flags = 1'b0; step();
    end

    // R4 R5 R11: byte packing into a word, threshold 4 bytes
    cfg(1'b1, 2'd0, 2'd0, 2'd0, 2'd2, 2'd0);
    en_req = 1'b1; step();
    do_push(32'h11); do_push(32'h22); do_push(32'h33);
    chk("R5 level", level, 3);
    chk("R4 below thr", drain_req, 0);
    do_push(32'h44);
    chk("R4 at thr", drain_req, 1);
    do_pop();
    chk("R11 valid", pop_valid, 1);
    chk("R5 packed", pop_data, 32'h44332211);
    chk("R5 level after", level, 0);
    step();
    chk("R11 one cycle", pop_valid, 0);
    en_req = 1'b0; step(); step();
    chk("R8 empty flush done", xfer_done, 1);

    // R5 R7: word to half-words, then underrun
    cfg(1'b1, 2'd0, 2'd0, 2'd2, 2'd1, 2'd0);
    en_req = 1'b1; step();
    do_push(32'hAABBCCDD);
    do_pop(); chk("R5 low half", pop_data, 32'h0000CCDD);
    do_pop(); chk("R5 high half", pop_data, 32'h0000AABB);
    do_pop();
    chk("R7 no data", pop_valid, 0);
    chk("R7 underrun", underrun, 1);
    clr_flags = 1'b1; step(); clr_flags = 1'b0;
    chk("R7 cleared", underrun, 0);

    // R6: overrun on full
    for (int k = 0; k < 4; k++) do_push(32'hA0B0C0D0 + k);
    chk("R6 full", level, 16);
    chk("R6 no fetch", fetch_req, 0);
    do_push(32'hDEADBEEF);
    chk("R6 overrun", overrun, 1);
    chk("R6 level kept", level, 16);
    clr_flags = 1'b1; step(); clr_flags = 1'b0;

    // R10: push and pop together
    do_pop(); do_pop();
    chk("R10 pre level", level, 12);
    push = 1'b1; push_data = 32'h01020304; pop = 1'b1; step();
    push = 1'b0; pop = 1'b0;
    chk("R10 level", level, 14);
    chk("R10 data", pop_data, 32'h0000C0D1);
    chk("R10 no overrun", overrun, 0);

    // R8: flush on disable
    en_req = 1'b0; step();
    chk("R8 inactive", active, 0);
    chk("R8 drain", drain_req, 1);
    chk("R8 not done", xfer_done, 0);
    for (int k = 0; k < 7; k++) do_pop();
    chk("R8 last data", pop_data, 32'h00000102);
    chk("R8 empty", level, 0);
    step();
    chk("R8 done", xfer_done, 1);

    // R8: partial final item
    cfg(1'b1, 2'd0, 2'd0, 2'd0, 2'd1, 2'd0);
    en_req = 1'b1; step();
    do_push(32'h5A); do_push(32'h6B); do_push(32'h7C);
    en_req = 1'b0; step();
    do_pop(); chk("R8 full half", pop_data, 32'h00006B5A);
    do_pop(); chk("R8 padded", pop_data, 32'h0000007C);
    step();
    chk("R8 partial done", xfer_done, 1);

    // R9: memory to peripheral discards on disable
    cfg(1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 2'd1);
    en_req = 1'b1; step();
    do_push(32'h01); do_push(32'h02);
    chk("R9 filled", level, 2);
    en_req = 1'b0; step();
    chk("R9 cleared", level, 0);
    chk("R9 no drain", drain_req, 0);
    step();
    chk("R9 no done", xfer_done, 0);

    // R3: direct mode with an invalid buffered setup
    cfg(1'b0, 2'd0, 2'd3, 2'd1, 2'd2, 2'd1);
    en_req = 1'b1; step();
    chk("R3 active", active, 1);
    chk("R3 no err", fifo_err, 0);
    chk("R3 preload fetch", fetch_req, 1);
    do_push(32'h1234);
    chk("R3 fetch off", fetch_req, 0);
    chk("R3 drain", drain_req, 1);
    do_pop();
    chk("R3 data", pop_data, 32'h00001234);
    chk("R3 refetch", fetch_req, 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule